// File: doc/BRIEF.md
# Byte-Coded Register CPU Core

A small multi-cycle processor core with four general registers of one byte each, a 16-bit program counter and zero and carry flags. It reads its program one byte per clock from a byte-wide memory through a combinational read port: the program counter drives the address and the addressed byte comes back in the same cycle. Instructions are one or three bytes long. Every byte read, whether opcode or operand, advances the program counter by one.

The core loads immediates into registers, adds and subtracts register pairs, and halts. Two jump opcodes are decoded but only step past their own byte. An opcode outside the defined set stops the core with an error indication. Debug outputs show the register contents and both flags, so a host or a bench can observe results after the core halts.

The reset input is asynchronous and active low. Inside the core its release is synchronised to the clock, so fetching starts on the third rising edge after the reset input goes high.

Top module: `byte_cpu`

## Requirements
- R1: While the core neither halts nor faults, it reads one byte per clock cycle at `mem_addr`, which equals the program counter, and the program counter increases by one after every byte read. The opcode byte that halts or faults the core also advances it.
- R2: Opcode 0x01 (load immediate) is followed by a register index byte and a value byte. The value is written into the indexed register, where index 0 is register A (`dbg_regs[7:0]`), 1 is B (`[15:8]`), 2 is C (`[23:16]`) and 3 is D (`[31:24]`).
- R3: A load immediate whose index byte is 4 or greater still takes its three bytes but changes no register. A load immediate never changes either flag.
- R4: Opcode 0x02 (add) is followed by a destination index byte and then a source index byte. It writes (dest + src) mod 256 into the destination and sets carry to the unsigned carry out of bit 7.
- R5: Opcode 0x03 (subtract) uses the same layout. It writes (dest - src) mod 256 into the destination and sets carry exactly when src is greater than dest as unsigned numbers.
- R6: After an add or a subtract, the zero flag is 1 exactly when the 8-bit result is 0.
- R7: If an add or a subtract names an index of 4 or greater as either operand, no register changes, the zero flag becomes 1 and the carry flag becomes 0.
- R8: Opcode 0xFF (halt) raises `halted`. From then on the address, all registers and both flags stay constant until reset.
- R9: Opcodes 0x04 and 0x05 are one byte long and change nothing except the program counter.
- R10: Any other opcode value raises `error`, which stays high. After it the core reads no more bytes and holds its address, registers and flags. `halted` stays low.
- R11: While `rst_n` is low, the program counter, all registers, both flags, `halted` and `error` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 16 | Program memory read address (program counter) |
| mem_data | input | 8 | Byte read from `mem_addr`, combinational |
| halted | output | 1 | Core stopped by a halt instruction |
| error | output | 1 | Core stopped by an undefined opcode |
| dbg_regs | output | 32 | Register contents, A in the low byte up to D in the high byte |
| dbg_zero | output | 1 | Zero flag |
| dbg_carry | output | 1 | Carry / borrow flag |

## Verification
The assertions assume that the memory always returns a defined byte at the address the core presents, in the same cycle. They also assume that the internal synchronised reset is the only reset the core sees, so they are disabled on that reset and not on the raw pin. The bench fills its whole memory with the halt opcode before it loads each program, so a core that runs past the program reads a defined byte and stops. The bench changes `rst_n` and memory contents only at falling edges, or while the core is halted or held in reset.

// File: rtl/byte_cpu_pkg.sv
package byte_cpu_pkg;

  localparam int unsigned OPC_W = 8;

  typedef enum logic [OPC_W-1:0] {
    OP_LDI  = 8'h01,
    OP_ADD  = 8'h02,
    OP_SUB  = 8'h03,
    OP_JMP  = 8'h04,
    OP_JZ   = 8'h05,
    OP_HALT = 8'hFF
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH = 3'd0,
    ST_ARG1  = 3'd1,
    ST_ARG2  = 3'd2,
    ST_HALT  = 3'd3,
    ST_FAULT = 3'd4
  } cpu_state_e;

  typedef enum logic [1:0] {
    EX_NONE = 2'd0,
    EX_LDI  = 2'd1,
    EX_ADD  = 2'd2,
    EX_SUB  = 2'd3
  } exec_kind_e;

endpackage

// File: rtl/byte_cpu_rst_sync.sv
module byte_cpu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/byte_cpu_regfile.sv
module byte_cpu_regfile #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NREG   = 4,
  localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [IDX_W-1:0]       rd_idx_l,
  input  logic [IDX_W-1:0]       rd_idx_r,
  output logic [DATA_W-1:0]      rd_l,
  output logic [DATA_W-1:0]      rd_r,
  output logic [NREG*DATA_W-1:0] dump
);
  logic [DATA_W-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic              en;
    logic [DATA_W-1:0] q;

    assign en = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (en) begin
        q <= wr_data;
      end
    end

    assign regs[g] = q;
    assign dump[g*DATA_W +: DATA_W] = q;
  end

  assign rd_l = regs[rd_idx_l];
  assign rd_r = regs[rd_idx_r];
endmodule

// File: rtl/byte_cpu_alu.sv
module byte_cpu_alu #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              is_sub,
  input  logic              operands_ok,
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              zero_out
);
  logic [DATA_W:0] wide;

  always_comb begin
    if (is_sub) begin
      wide = {1'b0, lhs} - {1'b0, rhs};
    end else begin
      wide = {1'b0, lhs} + {1'b0, rhs};
    end
    if (operands_ok) begin
      result    = wide[DATA_W-1:0];
      carry_out = wide[DATA_W];
    end else begin
      result    = '0;
      carry_out = 1'b0;
    end
    zero_out = (result == '0);
  end
endmodule

// File: rtl/byte_cpu_ctrl.sv
module byte_cpu_ctrl
  import byte_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mem_data,
  output logic [ADDR_W-1:0] pc,
  output exec_kind_e        kind,
  output logic [DATA_W-1:0] arg1,
  output logic              exec_stb,
  output logic              halted,
  output logic              fault
);
  cpu_state_e        state_q, state_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  exec_kind_e        kind_q, kind_d;
  logic [DATA_W-1:0] arg1_q, arg1_d;
  logic              fetch_en, kind_en, arg1_en;

  always_comb begin
    state_d  = state_q;
    kind_d   = kind_q;
    arg1_d   = arg1_q;
    pc_d     = pc_q + ADDR_W'(1);
    fetch_en = (state_q == ST_FETCH) || (state_q == ST_ARG1) || (state_q == ST_ARG2);
    kind_en  = (state_q == ST_FETCH);
    arg1_en  = (state_q == ST_ARG1);
    unique case (state_q)
      ST_FETCH: begin
        kind_d = EX_NONE;
        unique case (mem_data)
          DATA_W'(OP_LDI): begin kind_d = EX_LDI; state_d = ST_ARG1; end
          DATA_W'(OP_ADD): begin kind_d = EX_ADD; state_d = ST_ARG1; end
          DATA_W'(OP_SUB): begin kind_d = EX_SUB; state_d = ST_ARG1; end
          DATA_W'(OP_JMP),
          DATA_W'(OP_JZ):  state_d = ST_FETCH;
          DATA_W'(OP_HALT): state_d = ST_HALT;
          default:         state_d = ST_FAULT;
        endcase
      end
      ST_ARG1: begin
        arg1_d  = mem_data;
        state_d = ST_ARG2;
      end
      ST_ARG2: state_d = ST_FETCH;
      default: state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
      pc_q    <= '0;
      kind_q  <= EX_NONE;
      arg1_q  <= '0;
    end else begin
      state_q <= state_d;
      if (fetch_en) pc_q   <= pc_d;
      if (kind_en)  kind_q <= kind_d;
      if (arg1_en)  arg1_q <= arg1_d;
    end
  end

  assign pc       = pc_q;
  assign kind     = kind_q;
  assign arg1     = arg1_q;
  assign exec_stb = (state_q == ST_ARG2);
  assign halted   = (state_q == ST_HALT);
  assign fault    = (state_q == ST_FAULT);
endmodule

// File: rtl/byte_cpu.sv
module byte_cpu
  import byte_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NREG   = 4,
  localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic [DATA_W-1:0]      mem_data,
  output logic                   halted,
  output logic                   error,
  output logic [NREG*DATA_W-1:0] dbg_regs,
  output logic                   dbg_zero,
  output logic                   dbg_carry
);
  localparam logic [DATA_W-1:0] NREG_V = DATA_W'(NREG);

  logic              core_rst_n;
  exec_kind_e        kind;
  logic [DATA_W-1:0] arg1;
  logic              exec_stb;
  logic              dst_ok, src_ok, is_arith;
  logic              rf_we;
  logic [DATA_W-1:0] rf_wdata, rd_dst, rd_src;
  logic [DATA_W-1:0] alu_res;
  logic              alu_c, alu_z;
  logic              flag_en;
  logic              zero_q, zero_d, carry_q, carry_d;

  byte_cpu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  byte_cpu_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .mem_data (mem_data),
    .pc       (mem_addr),
    .kind     (kind),
    .arg1     (arg1),
    .exec_stb (exec_stb),
    .halted   (halted),
    .fault    (error)
  );

  assign dst_ok   = (arg1 < NREG_V);
  assign src_ok   = (mem_data < NREG_V);
  assign is_arith = (kind == EX_ADD) || (kind == EX_SUB);

  byte_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .is_sub      (kind == EX_SUB),
    .operands_ok (dst_ok && src_ok),
    .lhs         (rd_dst),
    .rhs         (rd_src),
    .result      (alu_res),
    .carry_out   (alu_c),
    .zero_out    (alu_z)
  );

  always_comb begin
    rf_we    = exec_stb && dst_ok &&
               ((kind == EX_LDI) || (is_arith && src_ok));
    rf_wdata = (kind == EX_LDI) ? mem_data : alu_res;
    flag_en  = exec_stb && is_arith;
    zero_d   = alu_z;
    carry_d  = alu_c;
  end

  byte_cpu_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .wr_en    (rf_we),
    .wr_idx   (arg1[IDX_W-1:0]),
    .wr_data  (rf_wdata),
    .rd_idx_l (arg1[IDX_W-1:0]),
    .rd_idx_r (mem_data[IDX_W-1:0]),
    .rd_l     (rd_dst),
    .rd_r     (rd_src),
    .dump     (dbg_regs)
  );

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      zero_q  <= 1'b0;
      carry_q <= 1'b0;
    end else if (flag_en) begin
      zero_q  <= zero_d;
      carry_q <= carry_d;
    end
  end

  assign dbg_zero  = zero_q;
  assign dbg_carry = carry_q;
endmodule

// File: rtl/byte_cpu_checker.sv
module byte_cpu_checker #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NREG   = 4
) (
  input logic                   clk,
  input logic                   core_rst_n,
  input logic [ADDR_W-1:0]      mem_addr,
  input logic                   halted,
  input logic                   error,
  input logic [NREG*DATA_W-1:0] dbg_regs,
  input logic                   dbg_zero,
  input logic                   dbg_carry
);
  // R1: one byte per cycle while running
  a_r1_pc_step: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!halted && !error) |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

  // R8: halt freezes everything
  a_r8_halt_holds: assert property (@(posedge clk) disable iff (!core_rst_n)
    halted |=> (halted && $stable(mem_addr) && $stable(dbg_regs) &&
                $stable(dbg_zero) && $stable(dbg_carry)));

  // R10: fault is sticky and freezes everything
  a_r10_fault_holds: assert property (@(posedge clk) disable iff (!core_rst_n)
    error |=> (error && $stable(mem_addr) && $stable(dbg_regs) &&
               $stable(dbg_zero) && $stable(dbg_carry)));

  // R10: halted and error never together
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(halted && error));

  // R11: first cycle out of reset starts clean
  a_r11_reset_clean: assert property (@(posedge clk)
    !core_rst_n |=> (!core_rst_n || (!halted && !error)));
endmodule

bind byte_cpu byte_cpu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NREG)) u_chk (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .mem_addr   (mem_addr),
  .halted     (halted),
  .error      (error),
  .dbg_regs   (dbg_regs),
  .dbg_zero   (dbg_zero),
  .dbg_carry  (dbg_carry)
);

// File: tb/byte_cpu_bench.sv
`timescale 1ns/1ps
module byte_cpu_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] mem_addr;
  logic [7:0]  mem_data;
  logic        halted, error;
  logic [31:0] dbg_regs;
  logic        dbg_zero, dbg_carry;
  logic [7:0]  mem [256];

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  assign mem_data = mem[mem_addr[7:0]];

  byte_cpu u_byte_cpu (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .halted    (halted),
    .error     (error),
    .dbg_regs  (dbg_regs),
    .dbg_zero  (dbg_zero),
    .dbg_carry (dbg_carry)
  );

  // {opcode, A, B, result in A, carry, zero}
  localparam logic [33:0] VEC [8] = '{
    {8'h02, 8'd5,   8'd10,  8'd15,  1'b0, 1'b0},
    {8'h02, 8'd200, 8'd100, 8'd44,  1'b1, 1'b0},
    {8'h02, 8'd128, 8'd128, 8'd0,   1'b1, 1'b1},
    {8'h02, 8'd0,   8'd0,   8'd0,   1'b0, 1'b1},
    {8'h03, 8'd5,   8'd10,  8'd251, 1'b1, 1'b0},
    {8'h03, 8'd10,  8'd5,   8'd5,   1'b0, 1'b0},
    {8'h03, 8'd7,   8'd7,   8'd0,   1'b0, 1'b1},
    {8'h03, 8'd0,   8'd255, 8'd1,   1'b1, 1'b0}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
  endtask

  task automatic put(input int addr, input logic [7:0] b);
    mem[addr] = b;
  endtask

  task automatic reset_core();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_stop();
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (halted || error) break;
    end
  endtask

  function automatic int reg_of(input int idx);
    return int'(dbg_regs[idx*8 +: 8]);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [33:0] v;
    rst_n = 1'b0;
    clear_mem();
    @(negedge clk);

    // R11: state while reset is held
    chk("R11", "addr in reset", int'(mem_addr), 0);
    chk("R11", "regs in reset", int'(dbg_regs), 0);
    chk("R11", "halted/error in reset", int'({halted, error}), 0);
    chk("R11", "flags in reset", int'({dbg_zero, dbg_carry}), 0);

    // Vector table: R4, R5, R6, R1
    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      clear_mem();
      put(0, 8'h01); put(1, 8'h00); put(2, v[25:18]);
      put(3, 8'h01); put(4, 8'h01); put(5, v[17:10]);
      put(6, v[33:26]); put(7, 8'h00); put(8, 8'h01);
      reset_core();
      run_stop();
      chk(v[33:26] == 8'h02 ? "R4" : "R5", "result A", reg_of(0), int'(v[9:2]));
      chk(v[33:26] == 8'h02 ? "R4" : "R5", "carry", int'(dbg_carry), int'(v[1]));
      chk("R6", "zero", int'(dbg_zero), int'(v[0]));
      chk("R4", "source B unchanged", reg_of(1), int'(v[17:10]));
      chk("R1", "addr after halt", int'(mem_addr), 10);
    end

    // R2, R3: load all registers, two bad indices
    clear_mem();
    put(0, 8'h01);  put(1, 8'h00);  put(2, 8'h11);
    put(3, 8'h01);  put(4, 8'h01);  put(5, 8'h22);
    put(6, 8'h01);  put(7, 8'h02);  put(8, 8'h33);
    put(9, 8'h01);  put(10, 8'h03); put(11, 8'h44);
    put(12, 8'h01); put(13, 8'h04); put(14, 8'h55);
    put(15, 8'h01); put(16, 8'hFF); put(17, 8'h66);
    reset_core();
    run_stop();
    chk("R2", "register bank", int'(dbg_regs), 32'h44332211);
    chk("R3", "bad index consumed", int'(mem_addr), 19);

    // R3: load immediate leaves flags
    clear_mem();
    put(0, 8'h01); put(1, 8'h00); put(2, 8'h80);
    put(3, 8'h02); put(4, 8'h00); put(5, 8'h00);
    put(6, 8'h01); put(7, 8'h02); put(8, 8'h09);
    reset_core();
    run_stop();
    chk("R3", "flags kept over load", int'({dbg_zero, dbg_carry}), 3);
    chk("R3", "C loaded", reg_of(2), 9);
    chk("R4", "A self add", reg_of(0), 0);

    // R4: D + D with D = 0x81
    clear_mem();
    put(0, 8'h01); put(1, 8'h03); put(2, 8'h81);
    put(3, 8'h02); put(4, 8'h03); put(5, 8'h03);
    reset_core();
    run_stop();
    chk("R4", "D doubled", reg_of(3), 2);
    chk("R4", "D carry", int'(dbg_carry), 1);

    // R7: out-of-range source after a borrowing subtract
    clear_mem();
    put(0, 8'h01); put(1, 8'h00); put(2, 8'd3);
    put(3, 8'h01); put(4, 8'h01); put(5, 8'd7);
    put(6, 8'h03); put(7, 8'h00); put(8, 8'h01);
    put(9, 8'h02); put(10, 8'h00); put(11, 8'h09);
    put(12, 8'h03); put(13, 8'h05); put(14, 8'h01);
    reset_core();
    run_stop();
    chk("R7", "A untouched", reg_of(0), 252);
    chk("R7", "B untouched", reg_of(1), 7);
    chk("R7", "zero set", int'(dbg_zero), 1);
    chk("R7", "carry clear", int'(dbg_carry), 0);
    chk("R7", "addr", int'(mem_addr), 16);

    // R9: jumps are one-byte no-ops
    clear_mem();
    put(0, 8'h04); put(1, 8'h05); put(2, 8'h04);
    put(3, 8'h01); put(4, 8'h00); put(5, 8'd42);
    reset_core();
    run_stop();
    chk("R9", "A after jumps", reg_of(0), 42);
    chk("R9", "addr after jumps", int'(mem_addr), 7);
    chk("R9", "flags untouched", int'({dbg_zero, dbg_carry}), 0);

    // R8: halted core holds
    repeat (6) @(negedge clk);
    chk("R8", "halted held", int'({halted, error}), 2);
    chk("R8", "addr held", int'(mem_addr), 7);
    chk("R8", "A held", reg_of(0), 42);

    // R10: undefined opcode
    clear_mem();
    put(0, 8'h01); put(1, 8'h00); put(2, 8'd5);
    put(3, 8'h07);
    put(4, 8'h01); put(5, 8'h00); put(6, 8'd9);
    reset_core();
    run_stop();
    chk("R10", "error/halted", int'({error, halted}), 2);
    chk("R10", "addr at fault", int'(mem_addr), 4);
    repeat (5) @(negedge clk);
    chk("R10", "addr held", int'(mem_addr), 4);
    chk("R10", "A held", reg_of(0), 5);
    chk("R10", "error sticky", int'(error), 1);

    // R11: reset clears a faulted core; R1: restart timing
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11", "clear after fault", int'({error, halted, dbg_zero, dbg_carry}), 0);
    chk("R11", "regs cleared", int'(dbg_regs), 0);
    chk("R11", "addr cleared", int'(mem_addr), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "no fetch during sync", int'(mem_addr), 0);
    @(negedge clk);
    chk("R1", "first fetch", int'(mem_addr), 1);
    @(negedge clk);
    chk("R1", "second fetch", int'(mem_addr), 2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule